// File: doc/BRIEF.md
# Input Delay Eye-Centering Calibrator

This block places the sampling instant of one deserialized data lane in the middle of its data eye. It runs on the divided word clock, which is one eighth of the lane bit rate for 8:1 deserialization. It works on an adjustable input delay line with 32 taps. The delay line is never loaded directly. The controller raises an enable toward the line, together with a direction select, and keeps it high only until the line's 5-bit tap readback reaches the tap the controller wants.

After a start request the controller works from the tap that the line already holds, which is 15 after the line's own reset. It walks down one tap at a time until it leaves the passing window or reaches tap 0. It then walks up until it leaves the window again or reaches tap 31. After every move it waits a programmable number of word-clock cycles so that the deserialized words reflect the new delay. Only then does it sample the pass/fail verdict from an external training-pattern checker.

When the search ends, the controller drives the line to the lower edge plus half the window width, rounded down, and reports done. If no tap passes, or if the readback stops following the enable (a stuck line), it reports fail and stops.

Top module: `dly_eye_center`

## Requirements
- R1: Out of reset the enable is low and done, fail and the final-tap output are all zero.
- R2: The enable is high only while the tap readback differs from the tap the controller wants. The direction output is 1 for increment and 0 for decrement. When done rises, the line holds exactly the reported final tap.
- R3: The first move after a start is a decrement (direction 0), except when the line is already at tap 0, in which case it is an increment.
- R4: The upward walk stops at the first failing tap above the passing window, or at tap 31. The highest tap the line reaches is therefore the larger of the start tap and min(upper edge + 1, 31).
- R5: For one contiguous window of passing taps, the final tap equals lower edge + floor((upper edge - lower edge) / 2).
- R6: Done stays high, with the final tap unchanged, until the next start. A start clears it.
- R7: Between the end of one enable pulse and the start of the next, the enable is low for at least the programmed settle count of cycles.
- R8: If the readback does not change within the timeout while the enable is high, fail rises, the enable drops, and the enable is never high for more than the timeout on an unchanged readback.
- R9: If no tap from 0 to 31 passes, fail rises and done stays low.
- R10: The enable is never high with direction 1 at tap 31, or with direction 0 at tap 0. The direction does not change while the enable stays high.
- R11: Done and fail are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration; honoured only when idle, done or failed |
| settle_cycles | input | SETTLE_W | Cycles to wait after each move before sampling the verdict |
| pat_ok | input | 1 | Training pattern received correctly at the current tap |
| tap_rd | input | TAP_W | Current tap readback from the delay line |
| dly_en | output | 1 | Step enable to the delay line |
| dly_up | output | 1 | Step direction: 1 increments, 0 decrements |
| done | output | 1 | Calibration finished, line centred |
| fail | output | 1 | Calibration aborted: no passing tap or stuck line |
| final_tap | output | TAP_W | Chosen centre tap |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- no step past either end of the line;
- a steady direction during a pulse;
- the minimum settle gap between pulses;
- the stall limit on an unmoving readback;
- done persisting until a start, and done never coinciding with fail.

Only the bench scenarios can show the outcome of a search: the chosen centre for windows at the bottom, at the top, a single tap, the whole line and a window away from the start tap, the first step direction, and how far the upward walk goes. They also exercise the fail paths for an empty window and a stuck line, using a behavioural delay-line model.

// File: rtl/dly_eye_pkg.sv
package dly_eye_pkg;
   typedef enum logic [2:0] {
      CAL_IDLE,
      CAL_SETTLE,
      CAL_SAMPLE,
      CAL_STEP,
      CAL_CENTER,
      CAL_DONE,
      CAL_FAIL
   } cal_state_e;
endpackage

// File: rtl/dly_settle_timer.sv
module dly_settle_timer #(
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [SETTLE_W-1:0] limit,
   output logic                expired
);
   logic [SETTLE_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         cnt <= '0;
      else if (!expired)
         cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt >= limit);
endmodule

// File: rtl/dly_tap_stepper.sv
module dly_tap_stepper #(
   parameter int TAP_W       = 5,
   parameter int TIMEOUT_CYC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [TAP_W-1:0] target,
   input  logic [TAP_W-1:0] tap_rd,
   output logic             step_en,
   output logic             step_up,
   output logic             arrived,
   output logic             timeout
);
   assign arrived = (tap_rd == target);
   assign step_en = active && !arrived;
   assign step_up = active && (target > tap_rd);

   generate
      if (TIMEOUT_CYC == 0) begin : g_no_wd
         assign timeout = 1'b0;
      end else begin : g_wd
         localparam int WD_W = $clog2(TIMEOUT_CYC + 1);
         logic [WD_W-1:0]  wd;
         logic [TAP_W-1:0] tap_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wd    <= '0;
               tap_q <= '0;
            end else begin
               tap_q <= tap_rd;
               if (!active || tap_rd != tap_q)
                  wd <= '0;
               else if (step_en)
                  wd <= wd + 1'b1;
            end
         end

         assign timeout = step_en && (wd == WD_W'(TIMEOUT_CYC - 1));
      end
   endgenerate
endmodule

// File: rtl/dly_eye_center.sv
module dly_eye_center
   import dly_eye_pkg::*;
#(
   parameter int TAP_W       = 5,
   parameter int NUM_TAPS    = 32,
   parameter int SETTLE_W    = 8,
   parameter int TIMEOUT_CYC = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic                pat_ok,
   input  logic [TAP_W-1:0]    tap_rd,
   output logic                dly_en,
   output logic                dly_up,
   output logic                done,
   output logic                fail,
   output logic [TAP_W-1:0]    final_tap
);
   localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(NUM_TAPS - 1);

   generate
      if (NUM_TAPS != (1 << TAP_W)) begin : g_bad_taps
         $error("NUM_TAPS must equal 2**TAP_W");
      end
      if (SETTLE_W < 1) begin : g_bad_settle
         $error("SETTLE_W must be at least 1");
      end
      if (TIMEOUT_CYC == 1) begin : g_bad_wd
         $error("TIMEOUT_CYC must be 0 or at least 2");
      end
   endgenerate

   cal_state_e       st;
   logic             phase_up, seen;
   logic [TAP_W-1:0] lo, hi, tgt;
   logic             mv_active, arrived, timeout, settled;
   logic             low_end, high_end, seen_n;
   logic [TAP_W-1:0] lo_n, hi_n, mid_n;

   assign mv_active = (st == CAL_STEP) || (st == CAL_CENTER);

   dly_tap_stepper #(.TAP_W(TAP_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (mv_active),
      .target  (tgt),
      .tap_rd  (tap_rd),
      .step_en (dly_en),
      .step_up (dly_up),
      .arrived (arrived),
      .timeout (timeout)
   );

   dly_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st == CAL_SETTLE),
      .limit   (settle_cycles),
      .expired (settled)
   );

   // Window bookkeeping for the tap being sampled now
   always_comb begin
      seen_n   = seen | pat_ok;
      low_end  = !phase_up && ((!pat_ok && seen) || tap_rd == '0);
      high_end =  phase_up && ((!pat_ok && seen) || tap_rd == TAP_MAX);
      lo_n     = (pat_ok && (!phase_up || !seen)) ? tap_rd : lo;
      hi_n     = (pat_ok && ( phase_up || !seen)) ? tap_rd : hi;
      mid_n    = lo_n + ((hi_n - lo_n) >> 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= CAL_IDLE;
         phase_up  <= 1'b0;
         seen      <= 1'b0;
         lo        <= '0;
         hi        <= '0;
         tgt       <= '0;
         final_tap <= '0;
      end else begin
         unique case (st)
            CAL_IDLE, CAL_DONE, CAL_FAIL: begin
               if (start) begin
                  st        <= CAL_SETTLE;
                  phase_up  <= 1'b0;
                  seen      <= 1'b0;
                  lo        <= '0;
                  hi        <= '0;
                  final_tap <= '0;
                  tgt       <= tap_rd;
               end
            end
            CAL_SETTLE: if (settled) st <= CAL_SAMPLE;
            CAL_SAMPLE: begin
               lo   <= lo_n;
               hi   <= hi_n;
               seen <= seen_n;
               if (!phase_up) begin
                  st <= CAL_STEP;
                  if (low_end) begin
                     phase_up <= 1'b1;
                     tgt      <= tap_rd + 1'b1;
                  end else begin
                     tgt      <= tap_rd - 1'b1;
                  end
               end else if (high_end) begin
                  if (!seen_n) begin
                     st <= CAL_FAIL;
                  end else begin
                     st        <= CAL_CENTER;
                     tgt       <= mid_n;
                     final_tap <= mid_n;
                  end
               end else begin
                  st  <= CAL_STEP;
                  tgt <= tap_rd + 1'b1;
               end
            end
            CAL_STEP: begin
               if (arrived)      st <= CAL_SETTLE;
               else if (timeout) st <= CAL_FAIL;
            end
            CAL_CENTER: begin
               if (arrived)      st <= CAL_DONE;
               else if (timeout) st <= CAL_FAIL;
            end
            default: st <= CAL_IDLE;
         endcase
      end
   end

   assign done = (st == CAL_DONE);
   assign fail = (st == CAL_FAIL);
endmodule

// File: rtl/dly_eye_center_chk.sv
module dly_eye_center_chk #(
   parameter int TAP_W       = 5,
   parameter int NUM_TAPS    = 32,
   parameter int SETTLE_W    = 8,
   parameter int TIMEOUT_CYC = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic [SETTLE_W-1:0] settle_cycles,
   input logic [TAP_W-1:0]    tap_rd,
   input logic                dly_en,
   input logic                dly_up,
   input logic                done,
   input logic                fail
);
   localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(NUM_TAPS - 1);
   localparam int GAP_W = SETTLE_W + 1;
   localparam int STL_W = $clog2(TIMEOUT_CYC + 2) + 1;

   logic [GAP_W-1:0] gap;
   logic             moved;
   logic [STL_W-1:0] stall;
   logic [TAP_W-1:0] prev_tap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap      <= '0;
         moved    <= 1'b0;
         stall    <= '0;
         prev_tap <= '0;
      end else begin
         prev_tap <= tap_rd;
         if (dly_en)        gap <= '0;
         else if (~&gap)    gap <= gap + 1'b1;
         if (start)         moved <= 1'b0;
         else if (dly_en)   moved <= 1'b1;
         if (dly_en && tap_rd == prev_tap) begin
            if (~&stall) stall <= stall + 1'b1;
         end else begin
            stall <= '0;
         end
      end
   end

   // R10
   edge_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dly_en |-> !((dly_up && tap_rd == TAP_MAX) || (!dly_up && tap_rd == '0)));

   // R10
   dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_en && $past(dly_en)) |-> $stable(dly_up));

   // R7
   settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dly_en) && moved) |-> (gap >= GAP_W'(settle_cycles)));

   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R11
   done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   generate
      if (TIMEOUT_CYC > 0) begin : g_stall
         // R8
         stall_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stall <= STL_W'(TIMEOUT_CYC));
      end
   endgenerate
endmodule

bind dly_eye_center dly_eye_center_chk #(
   .TAP_W(TAP_W), .NUM_TAPS(NUM_TAPS), .SETTLE_W(SETTLE_W), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
   .tap_rd(tap_rd), .dly_en(dly_en), .dly_up(dly_up), .done(done), .fail(fail)
);

// File: tb/tb_dly_eye_center.sv
module tb_dly_eye_center;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] settle_v = 8'd3;
   logic       pat_ok;
   logic [4:0] line_tap;
   logic       dly_en, dly_up, done, fail;
   logic [4:0] final_tap;

   logic       load = 1'b0;
   logic [4:0] load_val = '0;
   logic       stuck = 1'b0;
   int         win_lo = 0, win_hi = 31;

   int total = 0, bad = 0;
   bit finished = 0;

   typedef struct {
      bit    fl;
      int    fin;
      int    start_tap;
      int    max_exp;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   dly_eye_center dut (
      .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_v),
      .pat_ok(pat_ok), .tap_rd(line_tap), .dly_en(dly_en), .dly_up(dly_up),
      .done(done), .fail(fail), .final_tap(final_tap)
   );

   // Behavioural delay line and pattern checker
   always @(posedge clk) begin
      if (!rst_n) line_tap <= 5'd15;
      else if (load) line_tap <= load_val;
      else if (dly_en && !stuck) begin
         if (dly_up && line_tap != 5'd31) line_tap <= line_tap + 1'b1;
         else if (!dly_up && line_tap != 5'd0) line_tap <= line_tap - 1'b1;
      end
   end
   assign pat_ok = (int'(line_tap) >= win_lo) && (int'(line_tap) <= win_hi);

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor / scoreboard
   bit first_seen, first_up, prev_en, prev_end, gap_valid;
   int max_tap, min_gap, gap, viol;
   always @(negedge clk) begin
      if (rst_n) begin
         if (start) begin
            first_seen = 0; gap_valid = 0; gap = 0; min_gap = 1000; viol = 0;
            max_tap = int'(line_tap);
            prev_en = dly_en;
            prev_end = done | fail;
         end else begin
            if (dly_en) begin
               if (!first_seen) begin first_seen = 1; first_up = dly_up; end
               if (!prev_en && gap_valid && gap < min_gap) min_gap = gap;
               gap = 0; gap_valid = 1;
               if ((dly_up && line_tap == 5'd31) || (!dly_up && line_tap == 5'd0)) viol++;
            end else begin
               gap++;
            end
            prev_en = dly_en;
            if (int'(line_tap) > max_tap) max_tap = int'(line_tap);
            if ((done | fail) && !prev_end && sb.size() != 0) begin
               exp_t e;
               e = sb.pop_front();
               check(!(done && fail), "R11", done + fail, 1);
               check(fail == e.fl, e.tag, fail, e.fl);
               if (!e.fl) begin
                  check(final_tap == e.fin, "R5", final_tap, e.fin);
                  check(line_tap == e.fin, "R2", line_tap, e.fin);
                  check(first_up == (e.start_tap == 0), "R3", first_up, e.start_tap == 0);
                  check(max_tap == e.max_exp, "R4", max_tap, e.max_exp);
                  check(min_gap >= int'(settle_v), "R7", min_gap, settle_v);
                  check(viol == 0, "R10", viol, 0);
               end else begin
                  check(dly_en == 0, "R8", dly_en, 0);
                  check(done == 0, "R9", done, 0);
               end
            end
            prev_end = done | fail;
         end
      end
   end

   task automatic run_cal(input int st_tap, input int lo, input int hi,
                          input bit stuck_m, input int settle);
      exp_t e;
      bit was_done;
      e.start_tap = st_tap;
      e.fl = stuck_m || (lo > hi);
      e.tag = stuck_m ? "R8" : ((lo > hi) ? "R9" : "R5");
      e.fin = e.fl ? 0 : lo + (hi - lo) / 2;
      e.max_exp = ((hi + 1 > 31) ? 31 : hi + 1);
      if (lo > hi) e.max_exp = 31;
      if (st_tap > e.max_exp) e.max_exp = st_tap;
      @(posedge clk); #1;
      load = 1; load_val = 5'(st_tap); stuck = 0;
      win_lo = lo; win_hi = hi; settle_v = 8'(settle);
      @(posedge clk); #1;
      load = 0; stuck = stuck_m;
      was_done = done;
      sb.push_back(e);
      start = 1;
      @(posedge clk); #1;
      start = 0;
      if (was_done) check(done == 0, "R6", done, 0);
      while (sb.size() != 0) @(posedge clk);
      repeat (20) @(posedge clk);
      #1;
      if (!e.fl) begin
         check(done == 1, "R6", done, 1);
         check(final_tap == e.fin, "R6", final_tap, e.fin);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check(dly_en == 0, "R1", dly_en, 0);
      check(done == 0, "R1", done, 0);
      check(fail == 0, "R1", fail, 0);
      check(final_tap == 0, "R1", final_tap, 0);
      run_cal(15, 10, 20, 0, 3);
      run_cal(15, 0, 31, 0, 3);
      run_cal(15, 0, 3, 0, 2);
      run_cal(5, 28, 31, 0, 3);
      run_cal(25, 10, 20, 0, 0);
      run_cal(0, 0, 0, 0, 3);
      run_cal(31, 7, 7, 0, 6);
      run_cal(15, 5, 4, 0, 1);
      run_cal(12, 0, 31, 1, 3);
      run_cal(20, 19, 22, 0, 4);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule